// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a framebuffer fetch path and a display timing stage. It receives raw pixel words one at a time and turns each into an 8-bit red, green and blue triple. Software programs four settings: the number of bytes in a pixel, and one select setting per colour channel. Each select setting names the lowest bit of the channel's field, how many bits the field has, and an 8-bit fallback value. A channel shows its fallback value when its field is empty, when the pixel lies outside the visible area, or when the fetch path reports an underrun.

Pixel words arrive on a valid/ready stream. Each word carries an active-area flag and an underrun flag. A word transfers on a rising edge where `in_valid` and `in_ready` are both high. The result appears one cycle later on a registered valid/ready output. The output register holds its contents while `out_ready` is low. In that state `in_ready` is low, so back-pressure passes straight through to the source. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Configuration uses a plain single-cycle write port with no handshake.

Top module: `pcx_extractor`

## Requirements
- R1: While reset is asserted and just after it ends, `out_valid` is 0 and `in_ready` is 1. All settings reset to zero, which means one byte per pixel and empty fields for every channel.
- R2: `in_ready` equals `!out_valid || out_ready`. A transferred word produces `out_valid` = 1 on the next edge. While `out_valid && !out_ready`, the output data stays unchanged.
- R3: A write with `cfg_addr` = 0 sets bytes-per-pixel minus one from `cfg_wdata[4:3]`. Addresses 1, 2 and 3 set the red, green and blue select settings. In each select setting, bits 4:0 give the lowest bit, bits 11:8 give the bit count and bits 23:16 give the fallback value; all other bits are ignored. A word transferred in the same cycle as a write uses the settings from before the write.
- R4: With a bit count of 8, the channel output is pixel bits lowest+7 down to lowest.
- R5: With a bit count from 1 to 7, the field is placed at the top of the 8-bit output. Its bits are then repeated from the most significant bit down to fill the low bits.
- R6: With a bit count from 9 to 15, the channel output is the top 8 bits of the field.
- R7: Field bits at positions of 8 × bytes-per-pixel or above read as zero.
- R8: A channel with a bit count of 0 outputs its fallback value.
- R9: A word whose active flag is 0 outputs the fallback value on every channel.
- R10: A word whose underrun flag is 1 outputs the fallback value on every channel, whatever its active flag.
- R11: The active and underrun flags take effect together with the word they came with, including while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Setting write data |
| in_valid | input | 1 | Pixel word valid |
| in_ready | output | 1 | Block can accept a pixel word |
| in_word | input | PIX_W (32) | Raw pixel word |
| in_active | input | 1 | Pixel lies inside the visible area |
| in_underrun | input | 1 | Fetch path has underrun |
| out_valid | output | 1 | Output triple valid |
| out_ready | input | 1 | Consumer accepts the triple |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
A setting write and a pixel transfer can happen on the same edge. In that case the word must be decoded with the settings from before the write. The bench drives write strobes at random, independently of `in_valid` and of back-pressure, so such collisions occur often. Its model applies a write only after it has computed any word transferred on that same edge. When a collision happens, the comparison is tagged with that ordering rule, and a design that picks up the new setting early shows up as a mismatch. Fallback conditions that occur together, for example an underrun during an inactive pixel on a channel with an empty field, are also produced at random and judged by a fixed priority in the model.

// File: rtl/pcx_pkg.sv
`timescale 1ns/1ps
package pcx_pkg;
  typedef struct packed {
    logic [7:0] dflt;
    logic [3:0] len;
    logic [4:0] lo;
  } pcx_sel_t;

  typedef enum logic [1:0] {
    PCX_A_FMT = 2'd0,
    PCX_A_RED = 2'd1,
    PCX_A_GRN = 2'd2,
    PCX_A_BLU = 2'd3
  } pcx_addr_e;
endpackage

// File: rtl/pcx_cfg_regs.sv
`timescale 1ns/1ps
module pcx_cfg_regs
  import pcx_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int BPP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [BPP_W-1:0] bpp_m1,
  output pcx_sel_t         sel_o [NCH]
);
  localparam int FMT_LSB = 3;

  always_ff @(posedge clk) begin
    if (!rst_n) bpp_m1 <= '0;
    else if (we && addr == PCX_A_FMT) bpp_m1 <= wdata[FMT_LSB +: BPP_W];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n) sel_o[c] <= '0;
      else if (we && addr == 2'(c + 1)) begin
        sel_o[c].lo   <= wdata[4:0];
        sel_o[c].len  <= wdata[11:8];
        sel_o[c].dflt <= wdata[23:16];
      end
    end

    // R3: a select write lands in the addressed channel only
    a_r3_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(c + 1)) |=> (sel_o[c].len == $past(wdata[11:8])
                                     && sel_o[c].dflt == $past(wdata[23:16])));
    a_r3_sel_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == 2'(c + 1)) |=> $stable(sel_o[c]));
  end
endmodule

// File: rtl/pcx_channel.sv
`timescale 1ns/1ps
module pcx_channel
  import pcx_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int OUT_W = 8,
  parameter int BPP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] word,
  input  logic [BPP_W-1:0] bpp_m1,
  input  pcx_sel_t         sel,
  input  logic             active,
  input  logic             underrun,
  output logic [OUT_W-1:0] val
);
  localparam int IW    = $clog2(PIX_W);
  localparam int FLD_W = 16;

  logic [FLD_W-1:0] fld;
  logic [OUT_W-1:0] ext;
  int               lim;
  int               len;

  always_comb begin
    lim = (int'(bpp_m1) + 1) * 8;
    if (lim > PIX_W) lim = PIX_W;
    len = int'(sel.len);
    fld = '0;
    for (int k = 0; k < FLD_W; k++) begin
      if (k < len && (int'(sel.lo) + k) < lim)
        fld[k] = word[IW'(int'(sel.lo) + k)];
    end
    ext = '0;
    if (len >= OUT_W) begin
      for (int i = 0; i < OUT_W; i++) ext[i] = fld[4'(i + len - OUT_W)];
    end else if (len > 0) begin
      for (int i = 0; i < OUT_W; i++)
        ext[i] = fld[4'(len - 1 - ((OUT_W - 1 - i) % len))];
    end
  end

  assign val = (sel.len == '0 || !active || underrun) ? sel.dflt : ext;

  // R10: underrun forces the fallback value
  a_r10_underrun_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> val == sel.dflt);
  // R9: outside the visible area forces the fallback value
  a_r9_inactive_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> val == sel.dflt);
  // R8: empty field forces the fallback value
  a_r8_empty_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.len == '0) |-> val == sel.dflt);
endmodule

// File: rtl/pcx_extractor.sv
`timescale 1ns/1ps
module pcx_extractor
  import pcx_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_word,
  input  logic             in_active,
  input  logic             in_underrun,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_g,
  output logic [OUT_W-1:0] out_b
);
  localparam int NCH   = 3;
  localparam int BPP_W = $clog2(PIX_W / 8);

  logic [BPP_W-1:0] bpp_m1;
  pcx_sel_t         sel [NCH];
  logic [OUT_W-1:0] ch_val [NCH];
  logic [OUT_W-1:0] ch_q   [NCH];
  logic             take;

  pcx_cfg_regs #(.NCH(NCH), .BPP_W(BPP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .bpp_m1(bpp_m1), .sel_o(sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcx_channel #(.PIX_W(PIX_W), .OUT_W(OUT_W), .BPP_W(BPP_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .word(in_word), .bpp_m1(bpp_m1),
      .sel(sel[c]), .active(in_active), .underrun(in_underrun),
      .val(ch_val[c])
    );
    always_ff @(posedge clk) begin
      if (!rst_n)    ch_q[c] <= '0;
      else if (take) ch_q[c] <= ch_val[c];
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  assign out_r = ch_q[0];
  assign out_g = ch_q[1];
  assign out_b = ch_q[2];

  // R2: a stalled output holds its triple
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_r)
                                   && $stable(out_g) && $stable(out_b)));
  // R2: back-pressure blocks the input
  a_r2_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R2: a transfer yields a valid output next cycle
  a_r2_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/pcx_extractor_tb.sv
`timescale 1ns/1ps
module pcx_extractor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        in_valid, in_ready, in_active, in_underrun;
  logic [31:0] in_word;
  logic        out_valid, out_ready;
  logic [7:0]  out_r, out_g, out_b;

  always #5 clk = ~clk;

  pcx_extractor dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_active(in_active), .in_underrun(in_underrun),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  int    m_bpp;
  int    m_lo [3], m_len [3], m_dflt [3];
  bit    e_valid;
  int    e_val [3];
  string e_tag [3];

  function automatic int ref_chan(input logic [31:0] w, input int bpp, input int lo,
                                  input int len, input int dflt, input bit act,
                                  input bit und, output string tag);
    int f, acc, b, v;
    bit past;
    if (und)      begin tag = "R10 R11"; return dflt; end
    if (!act)     begin tag = "R9 R11";  return dflt; end
    if (len == 0) begin tag = "R8";      return dflt; end
    f = 0; past = 0;
    for (int k = 0; k < len; k++) begin
      if (lo + k < bpp * 8) f = f | (int'(w[lo + k]) << k);
      else past = 1;
    end
    if (len >= 8) v = (f >> (len - 8)) & 255;
    else begin
      acc = f; b = len;
      while (b < 8) begin acc = (acc << len) | f; b = b + len; end
      v = (acc >> (b - 8)) & 255;
    end
    if (past)          tag = "R7";
    else if (len > 8)  tag = "R6";
    else if (len < 8)  tag = "R5";
    else               tag = "R4";
    return v;
  endfunction

  // behavioural reference, updated on each edge from bench-driven inputs
  always @(posedge clk) begin
    bit acc_now;
    if (!rst_n) begin
      e_valid = 0; m_bpp = 1;
      for (int c = 0; c < 3; c++) begin m_lo[c] = 0; m_len[c] = 0; m_dflt[c] = 0; end
    end else begin
      acc_now = in_valid && (!e_valid || out_ready);
      if (acc_now) begin
        for (int c = 0; c < 3; c++) begin
          e_val[c] = ref_chan(in_word, m_bpp, m_lo[c], m_len[c], m_dflt[c],
                              in_active, in_underrun, e_tag[c]);
          if (cfg_we) e_tag[c] = {"R3 ", e_tag[c]};
        end
        e_valid = 1;
      end else if (out_ready) e_valid = 0;
      if (cfg_we) begin
        if (cfg_addr == 0) m_bpp = int'(cfg_wdata[4:3]) + 1;
        else begin
          m_lo[cfg_addr - 1]   = int'(cfg_wdata[4:0]);
          m_len[cfg_addr - 1]  = int'(cfg_wdata[11:8]);
          m_dflt[cfg_addr - 1] = int'(cfg_wdata[23:16]);
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 out_valid", int'(out_valid), int'(e_valid));
    chk("R2 in_ready", int'(in_ready), int'(!e_valid || out_ready));
    if (e_valid) begin
      chk({e_tag[0], " red"},   int'(out_r), e_val[0]);
      chk({e_tag[1], " green"}, int'(out_g), e_val[1]);
      chk({e_tag[2], " blue"},  int'(out_b), e_val[2]);
    end
  endtask

  task automatic drive_random();
    int a;
    cfg_we = ($urandom % 5) == 0;
    a = $urandom % 4;
    cfg_addr = 2'(a);
    cfg_wdata = $urandom;
    if (($urandom % 6) == 0) cfg_wdata[11:8] = 4'd0;
    if (($urandom % 4) == 0) cfg_wdata[11:8] = 4'd8;
    in_valid    = ($urandom % 4) != 0;
    in_word     = $urandom;
    in_active   = ($urandom % 8) != 0;
    in_underrun = ($urandom % 10) == 0;
    out_ready   = ($urandom % 4) != 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    in_valid = 0; in_word = 0; in_active = 0; in_underrun = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1;
    // R1: first word after reset sees zeroed settings (all fallback 0)
    in_valid = 1; in_active = 1; in_word = 32'hFFFF_FFFF; out_ready = 1;
    @(negedge clk);
    chk("R1 zero settings red", int'(out_r), 0);
    chk("R1 zero settings blue", int'(out_b), 0);
    // directed: 4-byte pixel, red 8 bits at 16 while a pixel transfers (R3)
    compare_all();
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'h18;
    in_word = 32'h00A5_3C0F;
    @(negedge clk); compare_all();
    cfg_addr = 1; cfg_wdata = 32'h0055_0810;
    @(negedge clk); compare_all();
    cfg_addr = 2; cfg_wdata = 32'h0000_0300;
    @(negedge clk); compare_all();
    cfg_addr = 3; cfg_wdata = 32'h0000_0C1C;
    @(negedge clk); compare_all();
    cfg_we = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compare_all();
      drive_random();
    end
    @(negedge clk);
    compare_all();
    done = 1;
    summary();
    $finish;
  end
endmodule